// File: doc/BRIEF.md
# Pulse-Network Iteration Stage

This block performs one iteration of a pulse-coupled neural network over a grey-scale image. The image arrives as a raster-ordered stream, row by row with the column index running fastest. Each stream word carries one neuron's state from the previous iteration: pixel value, feeding term, linking term, threshold and pulse bit. The stage updates every neuron from its own state and from the pulses of its eight neighbours. It forwards the updated state in the same raster order and counts how many neurons fired. That count is one element of the image's time signature.

Stages are chained, so successive iterations overlap in time. A buffered stage keeps one image row plus one pixel of state in registers. It can therefore update a neuron only once the neighbour below and to the right has arrived. A control state machine has three states. `ST_FILL` takes in the first H+1 pixels of a frame without producing output. `ST_RUN` emits one updated neuron for each accepted pixel. `ST_DRAIN` emits the last H+1 neurons on consecutive cycles once the input frame has ended, then returns to `ST_FILL`.

The transitions are:
- FILL to RUN on the (H+1)th accepted pixel.
- RUN to DRAIN on the final accepted pixel of the frame.
- DRAIN to FILL on the final emitted neuron.

Parameter `FIRST` selects a first-stage variant. It treats all incoming state as zero, needs no buffering and stays in `ST_RUN`. Parameter `LAST` selects a last-stage variant that forwards nothing.

Top module: `pnet_iter_stage`

## Requirements
- R1: After reset `out_valid` and `done` are 0 and `elem` is 0.
- R2: For the centre neuron the stage computes the following, where n is the count of firing neighbours among the eight around it and yc is the neuron's own previous pulse:
  - feed' = floor(feed/2) + pix
  - link' = floor(link/2) + n
  - u = feed' + floor(feed'·link'/8)
  - thr' = floor(thr/2) + (yc ? 200 : 0)
  - pulse' = (u > thr')

  `out_pix` repeats the pixel value unchanged.
- R3: Neighbours lying outside the image (column −1 or H, row −1 or V) count as not firing. No wrap-around between rows or frames takes place.
- R4: Each frame yields exactly H·V outputs, in raster order (index = row·H + column).
- R5: In a buffered stage, the output for pixel k is valid on the clock edge after the edge that accepts pixel k+H+1.
- R6: After the final pixel of a frame is accepted, a buffered stage emits the remaining H+1 outputs on H+1 consecutive cycles with no further input.
- R7: `done` is a one-cycle strobe that coincides with the final output of a frame. `elem` then equals the number of neurons that fired in that frame, and holds that value until the next `done`.
- R8: The firing count restarts at zero for every frame.
- R9: With `FIRST`=1 the feed, link, thr and pulse inputs have no effect, being treated as 0. Each accepted pixel produces its output on the next clock edge.
- R10: With `LAST`=1, `out_valid` and all forwarded data outputs stay 0, while `done` and `elem` work as in R7.
- R11: When its upstream stage drains back-to-back, a buffered stage raises `done` exactly H+2 cycles after the upstream `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_pix | input | SW | Pixel grey level |
| in_feed | input | FW | Previous feeding term |
| in_link | input | LW | Previous linking term |
| in_thr | input | TW | Previous threshold |
| in_pulse | input | 1 | Previous pulse |
| out_valid | output | 1 | Output word strobe |
| out_pix | output | SW | Pixel grey level forwarded |
| out_feed | output | FW | Updated feeding term |
| out_link | output | LW | Updated linking term |
| out_thr | output | TW | Updated threshold |
| out_pulse | output | 1 | Updated pulse |
| done | output | 1 | Frame finished strobe |
| elem | output | GW | Firing count of the last frame |

## Verification
The bench drives a three-stage chain (first, buffered, last) and targets four kinds of corner:
- **Image borders.** Random images fire on the edge columns, and a stage that wraps a neighbour across a row or a frame would report a wrong link count on column 0 or H−1.
- **Fill and drain.** Input gaps and back-to-back frames test these phases. A miscounted fill would shift valid by a cycle, and a broken drain would lose the last row's outputs or the `done` strobe.
- **Count reset.** An all-zero frame following bright frames catches a count that is not cleared.
- **First-stage variant.** Garbage on the first stage's unused state inputs exposes a variant that leaks them into its result.

// File: rtl/pnet_pkg.sv
package pnet_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } stage_st_t;

endpackage

// File: rtl/pnet_neuron.sv
module pnet_neuron #(
    parameter int SW  = 8,
    parameter int FW  = 10,
    parameter int LW  = 5,
    parameter int TW  = 10,
    parameter int VT  = 200,
    parameter int BSH = 3
) (
    input  logic [SW-1:0] s,
    input  logic [FW-1:0] f,
    input  logic [LW-1:0] l,
    input  logic [TW-1:0] t,
    input  logic          yc,
    input  logic [3:0]    nbr,
    output logic [FW-1:0] f_new,
    output logic [LW-1:0] l_new,
    output logic [TW-1:0] t_new,
    output logic          fire
);
    localparam int UW = FW + LW + 1;

    logic [UW-1:0] prod;
    logic [UW-1:0] act;

    always_comb begin
        f_new = (f >> 1) + FW'(s);
        l_new = (l >> 1) + LW'(nbr);
        prod  = UW'(f_new) * UW'(l_new);
        act   = UW'(f_new) + (prod >> BSH);
        t_new = (t >> 1) + (yc ? TW'(VT) : '0);
        fire  = act > UW'(t_new);
    end

endmodule

// File: rtl/pnet_delay.sv
module pnet_delay #(
    parameter int W = 8,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [D-1:0][W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift) begin
            q[0] <= din;
            for (int i = 1; i < D; i++) begin
                q[i] <= q[i-1];
            end
        end
    end

    assign dout = q[D-1];

endmodule

// File: rtl/pnet_window.sv
module pnet_window #(
    parameter int H   = 8,
    parameter int V   = 6,
    parameter int CLW = 3,
    parameter int RLW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift,
    input  logic           y_in,
    input  logic [CLW-1:0] col,
    input  logic [RLW-1:0] row,
    output logic           yc,
    output logic [3:0]     nbr
);
    localparam int WL = 2 * H + 2;

    logic [WL-1:0] hist;
    logic [WL:0]   win;
    logic          has_l, has_r, has_u, has_d;

    assign win = {hist, y_in};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift) begin
            hist <= win[WL-1:0];
        end
    end

    always_comb begin
        has_l = (col != '0);
        has_r = (col != CLW'(H - 1));
        has_u = (row != '0);
        has_d = (row != RLW'(V - 1));
        yc    = win[H+1];
        nbr   = 4'(win[H+2] & has_l)
              + 4'(win[H]   & has_r)
              + 4'(win[2*H+1] & has_u)
              + 4'(win[2*H+2] & has_u & has_l)
              + 4'(win[2*H]   & has_u & has_r)
              + 4'(win[1] & has_d)
              + 4'(win[2] & has_d & has_l)
              + 4'(win[0] & has_d & has_r);
    end

endmodule

// File: rtl/pnet_ctrl.sv
module pnet_ctrl
    import pnet_pkg::*;
#(
    parameter int H   = 8,
    parameter int V   = 6,
    parameter int LAG = 9,
    parameter int CLW = 3,
    parameter int RLW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           shift,
    output logic           emit,
    output logic           last,
    output logic [CLW-1:0] col,
    output logic [RLW-1:0] row
);
    localparam int P  = H * V;
    localparam int IW = (P > 1) ? $clog2(P) : 1;
    localparam stage_st_t ST_INIT = (LAG == 0) ? ST_RUN : ST_FILL;

    stage_st_t      st, st_nx;
    logic [IW-1:0]  in_idx;
    logic           in_end, fill_end;

    assign in_end   = (in_idx == IW'(P - 1));
    assign fill_end = (in_idx == IW'((LAG == 0) ? 0 : LAG - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_INIT;
            in_idx <= '0;
            col    <= '0;
            row    <= '0;
        end else begin
            st <= st_nx;
            if (in_valid && st != ST_DRAIN) begin
                in_idx <= in_end ? '0 : in_idx + 1'b1;
            end
            if (emit) begin
                if (col == CLW'(H - 1)) begin
                    col <= '0;
                    row <= (row == RLW'(V - 1)) ? '0 : row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end

    always_comb begin
        st_nx = st;
        shift = 1'b0;
        emit  = 1'b0;
        unique case (st)
            ST_FILL: begin
                shift = in_valid;
                if (in_valid && fill_end) st_nx = ST_RUN;
            end
            ST_RUN: begin
                shift = in_valid;
                emit  = in_valid;
                if (in_valid && in_end && LAG != 0) st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                shift = 1'b1;
                emit  = 1'b1;
                if (last) st_nx = ST_FILL;
            end
            default: st_nx = ST_INIT;
        endcase
        last = emit && col == CLW'(H - 1) && row == RLW'(V - 1);
    end

endmodule

// File: rtl/pnet_iter_stage.sv
module pnet_iter_stage #(
    parameter int H     = 8,
    parameter int V     = 6,
    parameter int SW    = 8,
    parameter int FW    = 10,
    parameter int LW    = 5,
    parameter int TW    = 10,
    parameter int VT    = 200,
    parameter int BSH   = 3,
    parameter bit FIRST = 1'b0,
    parameter bit LAST  = 1'b0,
    parameter int GW    = $clog2(H * V + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_pix,
    input  logic [FW-1:0] in_feed,
    input  logic [LW-1:0] in_link,
    input  logic [TW-1:0] in_thr,
    input  logic          in_pulse,
    output logic          out_valid,
    output logic [SW-1:0] out_pix,
    output logic [FW-1:0] out_feed,
    output logic [LW-1:0] out_link,
    output logic [TW-1:0] out_thr,
    output logic          out_pulse,
    output logic          done,
    output logic [GW-1:0] elem
);
    localparam int LAG = FIRST ? 0 : H + 1;
    localparam int CLW = (H > 1) ? $clog2(H) : 1;
    localparam int RLW = (V > 1) ? $clog2(V) : 1;
    localparam int DW  = SW + FW + LW + TW;

    logic           shift, emit, last;
    logic [CLW-1:0] col;
    logic [RLW-1:0] row;

    logic [SW-1:0]  c_s;
    logic [FW-1:0]  c_f, n_f;
    logic [LW-1:0]  c_l, n_l;
    logic [TW-1:0]  c_t, n_t;
    logic           c_yc, fire;
    logic [3:0]     c_nbr;

    pnet_ctrl #(.H(H), .V(V), .LAG(LAG), .CLW(CLW), .RLW(RLW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .shift(shift), .emit(emit), .last(last), .col(col), .row(row)
    );

    generate
        if (FIRST) begin : g_first
            assign c_s   = in_pix;
            assign c_f   = '0;
            assign c_l   = '0;
            assign c_t   = '0;
            assign c_yc  = 1'b0;
            assign c_nbr = '0;
        end else begin : g_buffered
            logic [DW-1:0] din, dctr;
            assign din = in_valid ? {in_pix, in_feed, in_link, in_thr} : '0;

            pnet_delay #(.W(DW), .D(H + 1)) u_delay (
                .clk(clk), .rst_n(rst_n), .shift(shift), .din(din), .dout(dctr)
            );
            assign {c_s, c_f, c_l, c_t} = dctr;

            pnet_window #(.H(H), .V(V), .CLW(CLW), .RLW(RLW)) u_win (
                .clk(clk), .rst_n(rst_n), .shift(shift),
                .y_in(in_valid & in_pulse), .col(col), .row(row),
                .yc(c_yc), .nbr(c_nbr)
            );
        end
    endgenerate

    pnet_neuron #(.SW(SW), .FW(FW), .LW(LW), .TW(TW), .VT(VT), .BSH(BSH)) u_neuron (
        .s(c_s), .f(c_f), .l(c_l), .t(c_t), .yc(c_yc), .nbr(c_nbr),
        .f_new(n_f), .l_new(n_l), .t_new(n_t), .fire(fire)
    );

    logic          v_q, y_q;
    logic [SW-1:0] s_q;
    logic [FW-1:0] f_q;
    logic [LW-1:0] l_q;
    logic [TW-1:0] t_q;
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= 1'b0;
            y_q  <= 1'b0;
            s_q  <= '0;
            f_q  <= '0;
            l_q  <= '0;
            t_q  <= '0;
            done <= 1'b0;
            elem <= '0;
            cnt  <= '0;
        end else begin
            v_q  <= emit;
            done <= last;
            if (emit) begin
                s_q <= c_s;
                f_q <= n_f;
                l_q <= n_l;
                t_q <= n_t;
                y_q <= fire;
            end
            if (last) begin
                elem <= cnt + GW'(fire);
                cnt  <= '0;
            end else if (emit && fire) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    generate
        if (LAST) begin : g_sink
            assign out_valid = 1'b0;
            assign out_pix   = '0;
            assign out_feed  = '0;
            assign out_link  = '0;
            assign out_thr   = '0;
            assign out_pulse = 1'b0;
        end else begin : g_fwd
            assign out_valid = v_q;
            assign out_pix   = s_q;
            assign out_feed  = f_q;
            assign out_link  = l_q;
            assign out_thr   = t_q;
            assign out_pulse = y_q;
        end
    endgenerate

endmodule

// File: rtl/pnet_iter_stage_chk.sv
module pnet_iter_stage_chk #(
    parameter int H     = 8,
    parameter int V     = 6,
    parameter bit FIRST = 1'b0,
    parameter bit LAST  = 1'b0,
    parameter int GW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic          done,
    input logic [GW-1:0] elem
);
    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done rides on the final forwarded output
    a_r7_done_with_output: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !LAST) |-> out_valid);

    // R7: elem changes only with done
    a_r7_elem_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(elem) |-> done);

    // R4: count never exceeds the neuron total
    a_r4_elem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        elem <= GW'(H * V));

    // R10: last stage forwards nothing
    a_r10_last_silent: assert property (@(posedge clk) disable iff (!rst_n)
        LAST |-> !out_valid);

    // R9: first stage answers on the next edge
    a_r9_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (FIRST && !LAST && in_valid) |=> out_valid);

endmodule

bind pnet_iter_stage pnet_iter_stage_chk #(
    .H(H), .V(V), .FIRST(FIRST), .LAST(LAST), .GW(GW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .done(done), .elem(elem)
);

// File: tb/pnet_iter_stage_bench.sv
module pnet_iter_stage_bench;
    localparam int H  = 8;
    localparam int V  = 6;
    localparam int P  = H * V;
    localparam int VT = 200;
    localparam int GW = $clog2(P + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       v0 = 1'b0, y0 = 1'b0;
    logic [7:0] s0 = '0;
    logic [9:0] f0 = '0, t0 = '0;
    logic [4:0] l0 = '0;

    logic v1, y1, d1; logic [7:0] s1; logic [9:0] f1, t1; logic [4:0] l1; logic [GW-1:0] e1;
    logic v2, y2, d2; logic [7:0] s2; logic [9:0] f2, t2; logic [4:0] l2; logic [GW-1:0] e2;
    logic v3, y3, d3; logic [7:0] s3; logic [9:0] f3, t3; logic [4:0] l3; logic [GW-1:0] e3;

    pnet_iter_stage #(.H(H), .V(V), .VT(VT), .FIRST(1'b1)) u_first (
        .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_pix(s0), .in_feed(f0),
        .in_link(l0), .in_thr(t0), .in_pulse(y0), .out_valid(v1), .out_pix(s1),
        .out_feed(f1), .out_link(l1), .out_thr(t1), .out_pulse(y1), .done(d1), .elem(e1));

    pnet_iter_stage #(.H(H), .V(V), .VT(VT)) u_pnet_iter_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_pix(s1), .in_feed(f1),
        .in_link(l1), .in_thr(t1), .in_pulse(y1), .out_valid(v2), .out_pix(s2),
        .out_feed(f2), .out_link(l2), .out_thr(t2), .out_pulse(y2), .done(d2), .elem(e2));

    pnet_iter_stage #(.H(H), .V(V), .VT(VT), .LAST(1'b1)) u_last (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_pix(s2), .in_feed(f2),
        .in_link(l2), .in_thr(t2), .in_pulse(y2), .out_valid(v3), .out_pix(s3),
        .out_feed(f3), .out_link(l3), .out_thr(t3), .out_pulse(y3), .done(d3), .elem(e3));

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model: iteration 0 is the zero state
    int img[P];
    int rf[4][P], rl[4][P], rt[4][P], ry[4][P];
    int gs[4];

    function automatic int pulse_at(int n, int r, int c);
        if (r < 0 || r >= V || c < 0 || c >= H) return 0;
        return ry[n][r*H + c];
    endfunction

    task automatic compute();
        for (int p = 0; p < P; p++) begin
            rf[0][p] = 0; rl[0][p] = 0; rt[0][p] = 0; ry[0][p] = 0;
        end
        for (int n = 1; n < 4; n++) begin
            gs[n] = 0;
            for (int p = 0; p < P; p++) begin
                int r, c, nb, u;
                r = p / H; c = p % H; nb = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (dr != 0 || dc != 0) nb += pulse_at(n-1, r+dr, c+dc);
                rf[n][p] = rf[n-1][p] / 2 + img[p];
                rl[n][p] = rl[n-1][p] / 2 + nb;
                u = rf[n][p] + (rf[n][p] * rl[n][p]) / 8;
                rt[n][p] = rt[n-1][p] / 2 + (ry[n-1][p] != 0 ? VT : 0);
                ry[n][p] = (u > rt[n][p]) ? 1 : 0;
                gs[n] += ry[n][p];
            end
        end
    endtask

    // monitor state
    int cyc = 0;
    bit pend1 = 0, pend2 = 0;
    int q1 = 0, q2 = 0, acc2 = 0, drain2 = 0;
    int t_d1 = -1, t_d2 = -1, t_d3 = -1;
    bit mon_on = 0;

    always @(negedge clk) begin
        if (mon_on && !finished) begin
            bit ev2, ed1, ed2;
            cyc++;
            // first stage: one-cycle latency, zero prior state
            ed1 = pend1 && (q1 == P-1);
            chk(v1 == pend1, "R9 first-stage valid latency", v1, pend1);
            chk(d1 == ed1, "R7 first-stage done timing", d1, ed1);
            if (v1) begin
                chk(s1 == img[q1], "R2 first pix", s1, img[q1]);
                chk(f1 == rf[1][q1], "R9 first feed ignores inputs", f1, rf[1][q1]);
                chk(l1 == rl[1][q1], "R9 first link", l1, rl[1][q1]);
                chk(t1 == rt[1][q1], "R9 first thr", t1, rt[1][q1]);
                chk(y1 == ry[1][q1], "R9 first pulse", y1, ry[1][q1]);
                q1 = (q1 == P-1) ? 0 : q1 + 1;
            end
            if (d1) begin
                chk(e1 == gs[1], "R7 first elem", e1, gs[1]);
                t_d1 = cyc;
            end
            // buffered stage: fill, run, drain timing
            ev2 = 0;
            if (drain2 > 0) begin
                ev2 = 1; drain2--;
            end else if (pend2) begin
                if (acc2 >= H+1) ev2 = 1;
                acc2++;
                if (acc2 == P) begin acc2 = 0; drain2 = H+1; end
            end
            ed2 = ev2 && (q2 == P-1);
            chk(v2 == ev2, "R5 R6 buffered valid timing", v2, ev2);
            chk(d2 == ed2, "R7 buffered done timing", d2, ed2);
            if (v2) begin
                chk(s2 == img[q2], "R4 buffered pix order", s2, img[q2]);
                chk(f2 == rf[2][q2], "R2 buffered feed", f2, rf[2][q2]);
                chk(l2 == rl[2][q2], "R3 buffered link with borders", l2, rl[2][q2]);
                chk(t2 == rt[2][q2], "R2 buffered thr", t2, rt[2][q2]);
                chk(y2 == ry[2][q2], "R2 buffered pulse", y2, ry[2][q2]);
                q2 = (q2 == P-1) ? 0 : q2 + 1;
            end
            if (d2) begin
                chk(e2 == gs[2], "R8 buffered elem per frame", e2, gs[2]);
                t_d2 = cyc;
            end
            // last stage
            chk(v3 == 0 && s3 == 0 && f3 == 0 && l3 == 0 && t3 == 0 && y3 == 0,
                "R10 last stage silent", v3, 0);
            if (d3) begin
                chk(e3 == gs[3], "R10 last elem", e3, gs[3]);
                t_d3 = cyc;
            end
            pend1 = v0;
            pend2 = v1;
        end
    end

    task automatic drive_frame(input int mode);
        for (int p = 0; p < P; p++) begin
            case (mode)
                0: img[p] = $urandom_range(0, 255);
                1: img[p] = ((p % H) * 29 + (p / H) * 7) % 256;
                2: img[p] = 0;
                3: img[p] = 255;
                default: img[p] = (((p % H) + (p / H)) % 2) * 200;
            endcase
        end
        compute();
        t_d1 = -1; t_d2 = -1; t_d3 = -1;
        for (int p = 0; p < P; p++) begin
            int gaps;
            gaps = (mode == 0) ? $urandom_range(0, 2) : ((mode == 3 && p % 3 == 0) ? 1 : 0);
            repeat (gaps) begin
                @(posedge clk); #1;
                v0 = 1'b0;
            end
            @(posedge clk); #1;
            v0 = 1'b1;
            s0 = 8'(img[p]);
            f0 = 10'($urandom); l0 = 5'($urandom); t0 = 10'($urandom); y0 = 1'($urandom);
        end
        @(posedge clk); #1;
        v0 = 1'b0;
        for (int w = 0; w < 400 && t_d3 < 0; w++) @(posedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(t_d3 >= 0, "R7 last stage done seen", t_d3, 1);
        chk(t_d2 - t_d1 == H + 2, "R11 buffered done lag", t_d2 - t_d1, H + 2);
        chk(t_d3 - t_d2 == H + 2, "R11 last done lag", t_d3 - t_d2, H + 2);
        chk(e2 == gs[2], "R7 elem holds after done", e2, gs[2]);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(v2 == 0 && d2 == 0, "R1 reset strobes low", v2 + d2, 0);
        chk(e2 == 0 && e1 == 0 && e3 == 0, "R1 reset elem zero", e2, 0);
        @(posedge clk); #1;
        mon_on = 1;
        drive_frame(0);
        drive_frame(3);
        drive_frame(2);
        drive_frame(1);
        drive_frame(4);
        drive_frame(0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule